// File: doc/BRIEF.md
# Microcontroller Execute Stage

This block is the execute stage of a small 8-bit microcontroller pipeline that runs ten instruction kinds: branch when not equal, decrement, exclusive-OR, port read, port write, load immediate, relative call, return, relative jump and direct store. Each cycle the decode stage may present one instruction with a valid strobe. With it come an operation code, the two register operands, a raw constant field, the program counter (already advanced by one), the stack pointer, the word popped from the stack and the value read from the addressed port.

Per instruction, the stage picks the operands. Program counter and stack pointer arithmetic runs on a 16-bit adder path, with short relative offsets sign-extended first. Register arithmetic runs on an 8-bit path. The stage keeps the zero flag that decides the conditional branch. One cycle after the strobe it registers the results:
- the next program counter and the next stack pointer;
- a register write-back value with its enable;
- a data memory address and data with a write enable, used for the call push and the direct store;
- a port number and data with a write enable.

Top module: `exec_stage`

## Requirements
- R1: While rst_n is low, and on the first clock edge after it, every registered output is zero: out_valid, the three write enables, the zero flag, the addresses, the data values, next_pc and next_sp.
- R2: Opcode 1 (branch if not equal) sets next_pc to in_pc plus in_k[6:0] read as a signed 7-bit value, but only if the zero flag is 0. If the flag is 1, next_pc equals in_pc.
- R3: Opcode 9 (relative jump) sets next_pc to in_pc plus in_k[11:0] read as a signed 12-bit value, with the 16-bit sum wrapping.
- R4: Opcode 7 (relative call) drives mem_we=1, mem_addr=in_sp and mem_wdata=in_pc. It sets next_sp to in_sp minus 2 and next_pc to in_pc plus the signed 12-bit in_k[11:0].
- R5: Opcode 8 (return) sets next_pc to in_pop and next_sp to in_sp plus 2, and raises no write enable.
- R6: Opcode 2 (decrement) drives rf_we=1 and rf_wdata=in_rd minus 1, wrapping modulo 256. The zero flag becomes 1 exactly when that result is 0.
- R7: Opcode 3 (exclusive-OR) drives rf_we=1 and rf_wdata=in_rd XOR in_rs. The zero flag becomes 1 exactly when that result is 0.
- R8: Opcode 6 (load immediate) drives rf_we=1 and rf_wdata=in_k[7:0].
- R9: Opcode 4 (port read) drives rf_we=1 and rf_wdata=in_port. Opcode 5 (port write) drives port_we=1, port_addr=in_k[5:0] and port_wdata=in_rs. At most one of rf_we, mem_we and port_we is ever high.
- R10: Opcode 10 (direct store) drives mem_we=1, mem_addr=in_k and mem_wdata={8'h00,in_rs}.
- R11: Every valid opcode other than 2 and 3 leaves the zero flag unchanged.
- R12: Opcodes 0 and 11 to 15 are no-ops: next_pc=in_pc, next_sp=in_sp, and all write enables stay 0.
- R13: out_valid is in_valid delayed by one cycle. Without in_valid, no write enable rises and the zero flag and all result outputs hold.
- R14: For every opcode other than 7 and 8, next_sp equals in_sp. Opcodes other than 1, 7, 8 and 9 set next_pc to in_pc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_op | input | 4 | Operation code |
| in_rd | input | 8 | Destination register operand |
| in_rs | input | 8 | Source register operand |
| in_k | input | 16 | Raw constant field or port number |
| in_pc | input | 16 | Program counter, already incremented |
| in_sp | input | 16 | Stack pointer |
| in_pop | input | 16 | Word read from the top of the stack |
| in_port | input | 8 | Value read from the addressed port |
| out_valid | output | 1 | Results valid |
| rf_we | output | 1 | Register write enable |
| rf_wdata | output | 8 | Register write-back value |
| mem_we | output | 1 | Data memory write enable |
| mem_addr | output | 16 | Data memory address |
| mem_wdata | output | 16 | Data memory write data |
| port_we | output | 1 | Port write enable |
| port_addr | output | 6 | Port number |
| port_wdata | output | 8 | Port write data |
| next_pc | output | 16 | Program counter for fetch |
| next_sp | output | 16 | Updated stack pointer |
| z_flag | output | 1 | Zero flag |

## Verification
The bench builds the block with its default parameters:
- 16-bit addresses and 8-bit data;
- a 7-bit branch offset and a 12-bit jump offset;
- a 6-bit port number and a stack step of 2.

These values bring both sign-extension boundaries within reach: offsets of -64, 63, -2048 and 2047. They also bring the 16-bit wrap of the program counter within reach. The zero flag is set and cleared by decrement and exclusive-OR, and the bench then shows a branch both taken and not taken. Decrement also wraps from 0 to 255.

// File: rtl/exec_stage.sv
module exec_stage #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int BR_W    = 7,
  parameter int JMP_W   = 12,
  parameter int PORT_W  = 6,
  parameter int SP_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_op,
  input  logic [DW-1:0]     in_rd,
  input  logic [DW-1:0]     in_rs,
  input  logic [AW-1:0]     in_k,
  input  logic [AW-1:0]     in_pc,
  input  logic [AW-1:0]     in_sp,
  input  logic [AW-1:0]     in_pop,
  input  logic [DW-1:0]     in_port,
  output logic              out_valid,
  output logic              rf_we,
  output logic [DW-1:0]     rf_wdata,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [AW-1:0]     mem_wdata,
  output logic              port_we,
  output logic [PORT_W-1:0] port_addr,
  output logic [DW-1:0]     port_wdata,
  output logic [AW-1:0]     next_pc,
  output logic [AW-1:0]     next_sp,
  output logic              z_flag
);

  localparam logic [3:0] OP_BNE  = 4'd1;
  localparam logic [3:0] OP_DEC  = 4'd2;
  localparam logic [3:0] OP_XOR  = 4'd3;
  localparam logic [3:0] OP_PIN  = 4'd4;
  localparam logic [3:0] OP_POUT = 4'd5;
  localparam logic [3:0] OP_LDK  = 4'd6;
  localparam logic [3:0] OP_CALL = 4'd7;
  localparam logic [3:0] OP_RETN = 4'd8;
  localparam logic [3:0] OP_JMP  = 4'd9;
  localparam logic [3:0] OP_STD  = 4'd10;
  localparam logic [AW-1:0] STEP = AW'(SP_STEP);

  logic is_bne, is_dec, is_xor, is_pin, is_pout, is_ldk;
  logic is_call, is_retn, is_jmp, is_std;

  assign is_bne  = in_op == OP_BNE;
  assign is_dec  = in_op == OP_DEC;
  assign is_xor  = in_op == OP_XOR;
  assign is_pin  = in_op == OP_PIN;
  assign is_pout = in_op == OP_POUT;
  assign is_ldk  = in_op == OP_LDK;
  assign is_call = in_op == OP_CALL;
  assign is_retn = in_op == OP_RETN;
  assign is_jmp  = in_op == OP_JMP;
  assign is_std  = in_op == OP_STD;

  // 16-bit address path: one adder, offset chosen per opcode
  logic [AW-1:0] br_off, jmp_off, pc_off, pc_sum, pc_nx, sp_nx;
  logic          take;

  assign br_off  = {{(AW-BR_W){in_k[BR_W-1]}}, in_k[BR_W-1:0]};
  assign jmp_off = {{(AW-JMP_W){in_k[JMP_W-1]}}, in_k[JMP_W-1:0]};
  assign pc_off  = is_bne ? br_off : jmp_off;
  assign pc_sum  = in_pc + pc_off;
  assign take    = (is_bne && !z_flag) || is_jmp || is_call;
  assign pc_nx   = is_retn ? in_pop : (take ? pc_sum : in_pc);
  assign sp_nx   = is_call ? in_sp - STEP :
                   is_retn ? in_sp + STEP : in_sp;

  // 8-bit register path
  logic [DW-1:0] alu_res, wb_val;
  logic          alu_use, wb_en;

  assign alu_res = is_dec ? in_rd - DW'(1) : in_rd ^ in_rs;
  assign alu_use = is_dec || is_xor;
  assign wb_en   = alu_use || is_pin || is_ldk;

  always_comb begin
    wb_val = alu_res;
    if (is_ldk)      wb_val = in_k[DW-1:0];
    else if (is_pin) wb_val = in_port;
  end

  // memory path: push of return address or direct store
  logic          mem_en;
  logic [AW-1:0] mem_a, mem_d;

  assign mem_en = is_call || is_std;
  assign mem_a  = is_call ? in_sp : in_k;
  assign mem_d  = is_call ? in_pc : {{(AW-DW){1'b0}}, in_rs};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      rf_we      <= 1'b0;
      rf_wdata   <= '0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      port_we    <= 1'b0;
      port_addr  <= '0;
      port_wdata <= '0;
      next_pc    <= '0;
      next_sp    <= '0;
      z_flag     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      rf_we     <= in_valid && wb_en;
      mem_we    <= in_valid && mem_en;
      port_we   <= in_valid && is_pout;
      if (in_valid) begin
        next_pc <= pc_nx;
        next_sp <= sp_nx;
        if (wb_en) rf_wdata <= wb_val;
        if (mem_en) begin
          mem_addr  <= mem_a;
          mem_wdata <= mem_d;
        end
        if (is_pout || is_pin) port_addr <= in_k[PORT_W-1:0];
        if (is_pout) port_wdata <= in_rs;
        if (alu_use) z_flag <= (alu_res == '0);
      end
    end
  end

endmodule

// File: rtl/exec_stage_chk.sv
module exec_stage_chk #(
  parameter int AW = 16,
  parameter int SP_STEP = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [3:0]    in_op,
  input logic [AW-1:0] in_pc,
  input logic [AW-1:0] in_sp,
  input logic [AW-1:0] in_pop,
  input logic          out_valid,
  input logic          rf_we,
  input logic          mem_we,
  input logic          port_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] next_pc,
  input logic [AW-1:0] next_sp,
  input logic          z_flag
);
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R13
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !(rf_we || mem_we || port_we)); // R13
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, mem_we, port_we})); // R9
  AST_CALL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 4'd7) |=> (mem_we && mem_addr == $past(in_sp)
      && next_sp == $past(in_sp) - AW'(SP_STEP))); // R4
  AST_RET_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 4'd8) |=> (next_pc == $past(in_pop)
      && next_sp == $past(in_sp) + AW'(SP_STEP))); // R5
  AST_Z_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op != 4'd2 && in_op != 4'd3) |=> $stable(z_flag)); // R11
  AST_UNDEF_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op == 4'd0 || in_op > 4'd10)) |=>
      (next_pc == $past(in_pc) && !rf_we && !mem_we && !port_we)); // R12
endmodule

bind exec_stage exec_stage_chk #(.AW(AW), .SP_STEP(SP_STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
  .in_pc(in_pc), .in_sp(in_sp), .in_pop(in_pop), .out_valid(out_valid),
  .rf_we(rf_we), .mem_we(mem_we), .port_we(port_we), .mem_addr(mem_addr),
  .next_pc(next_pc), .next_sp(next_sp), .z_flag(z_flag)
);

// File: tb/exec_stage_tb.sv
module exec_stage_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [3:0] in_op = '0;
  logic [7:0] in_rd = '0, in_rs = '0, in_port = '0;
  logic [15:0] in_k = '0, in_pc = '0, in_sp = '0, in_pop = '0;
  logic out_valid, rf_we, mem_we, port_we, z_flag;
  logic [7:0] rf_wdata, port_wdata;
  logic [5:0] port_addr;
  logic [15:0] mem_addr, mem_wdata, next_pc, next_sp;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  exec_stage u_dut (.*);

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [7:0] rd, input logic [7:0] rs,
                       input logic [15:0] k, input logic [15:0] pc, input logic [15:0] sp,
                       input logic [15:0] pop, input logic [7:0] pv);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_rd = rd; in_rs = rs; in_k = k;
    in_pc = pc; in_sp = sp; in_pop = pop; in_port = pv;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 valid", {15'b0, out_valid}, 16'h0);
    chk("R1 strobes", {13'b0, rf_we, mem_we, port_we}, 16'h0);
    chk("R1 z", {15'b0, z_flag}, 16'h0);
    chk("R1 pc", next_pc, 16'h0);
    chk("R1 sp", next_sp, 16'h0);
    chk("R1 mem", mem_addr | mem_wdata, 16'h0);
    chk("R1 port", {2'b0, port_addr, port_wdata}, 16'h0);
    chk("R1 rf data", {8'h0, rf_wdata}, 16'h0);
  endtask

  task automatic t_branch_taken;
    issue(4'd1, 0, 0, 16'h007F, 16'h0100, 16'h00F0, 0, 0);
    chk("R2 taken -1", next_pc, 16'h00FF);
    chk("R13 out_valid", {15'b0, out_valid}, 16'h1);
    chk("R14 sp", next_sp, 16'h00F0);
    issue(4'd1, 0, 0, 16'hFF3F, 16'h0100, 16'h00F0, 0, 0);
    chk("R2 taken +63", next_pc, 16'h013F);
    issue(4'd1, 0, 0, 16'h0040, 16'h0100, 16'h00F0, 0, 0);
    chk("R2 taken -64", next_pc, 16'h00C0);
    chk("R11 z after bne", {15'b0, z_flag}, 16'h0);
  endtask

  task automatic t_dec_and_branch;
    issue(4'd2, 8'h01, 0, 0, 16'h0200, 16'h00F0, 0, 0);
    chk("R6 dec data", {8'h0, rf_wdata}, 16'h0000);
    chk("R6 dec we", {15'b0, rf_we}, 16'h1);
    chk("R6 z set", {15'b0, z_flag}, 16'h1);
    chk("R14 pc dec", next_pc, 16'h0200);
    issue(4'd1, 0, 0, 16'h0010, 16'h0300, 16'h00F0, 0, 0);
    chk("R2 not taken", next_pc, 16'h0300);
    issue(4'd6, 0, 0, 16'h00A5, 16'h0301, 16'h00F0, 0, 0);
    chk("R8 ldi", {8'h0, rf_wdata}, 16'h00A5);
    chk("R11 z held by ldi", {15'b0, z_flag}, 16'h1);
    issue(4'd2, 8'h00, 0, 0, 16'h0302, 16'h00F0, 0, 0);
    chk("R6 dec wrap", {8'h0, rf_wdata}, 16'h00FF);
    chk("R6 z clear", {15'b0, z_flag}, 16'h0);
  endtask

  task automatic t_xor;
    issue(4'd3, 8'h5A, 8'h0F, 0, 16'h0400, 16'h00F0, 0, 0);
    chk("R7 xor", {8'h0, rf_wdata}, 16'h0055);
    chk("R7 z clear", {15'b0, z_flag}, 16'h0);
    issue(4'd3, 8'h3C, 8'h3C, 0, 16'h0401, 16'h00F0, 0, 0);
    chk("R7 xor zero", {8'h0, rf_wdata}, 16'h0000);
    chk("R7 z set", {15'b0, z_flag}, 16'h1);
  endtask

  task automatic t_jump;
    issue(4'd9, 0, 0, 16'h0800, 16'h1000, 16'h00F0, 0, 0);
    chk("R3 jmp -2048", next_pc, 16'h0800);
    issue(4'd9, 0, 0, 16'hF7FF, 16'h1000, 16'h00F0, 0, 0);
    chk("R3 jmp +2047", next_pc, 16'h17FF);
    issue(4'd9, 0, 0, 16'h0FFE, 16'h0001, 16'h00F0, 0, 0);
    chk("R3 jmp wrap", next_pc, 16'hFFFF);
  endtask

  task automatic t_call_ret;
    issue(4'd7, 0, 0, 16'h0010, 16'h0500, 16'h00FE, 0, 0);
    chk("R4 call pc", next_pc, 16'h0510);
    chk("R4 call sp", next_sp, 16'h00FC);
    chk("R4 push addr", mem_addr, 16'h00FE);
    chk("R4 push data", mem_wdata, 16'h0500);
    chk("R4 push we", {15'b0, mem_we}, 16'h1);
    issue(4'd8, 0, 0, 16'h0010, 16'h0511, 16'h00FC, 16'h0500, 0);
    chk("R5 ret pc", next_pc, 16'h0500);
    chk("R5 ret sp", next_sp, 16'h00FE);
    chk("R5 ret no we", {13'b0, rf_we, mem_we, port_we}, 16'h0);
  endtask

  task automatic t_ports_store;
    issue(4'd5, 0, 8'hC3, 16'hFFAA, 16'h0600, 16'h00F0, 0, 0);
    chk("R9 out we", {15'b0, port_we}, 16'h1);
    chk("R9 out addr", {10'b0, port_addr}, 16'h002A);
    chk("R9 out data", {8'h0, port_wdata}, 16'h00C3);
    chk("R9 out no rf", {15'b0, rf_we}, 16'h0);
    issue(4'd4, 0, 0, 16'h0005, 16'h0601, 16'h00F0, 0, 8'h77);
    chk("R9 in data", {8'h0, rf_wdata}, 16'h0077);
    chk("R9 in no port we", {14'b0, rf_we, port_we}, 16'h2);
    issue(4'd10, 0, 8'h99, 16'hBEEF, 16'h0602, 16'h00F0, 0, 0);
    chk("R10 sts addr", mem_addr, 16'hBEEF);
    chk("R10 sts data", mem_wdata, 16'h0099);
    chk("R10 sts we", {15'b0, mem_we}, 16'h1);
    chk("R14 sts pc", next_pc, 16'h0602);
  endtask

  task automatic t_undef_idle;
    issue(4'd15, 8'h11, 8'h22, 16'h1234, 16'h0700, 16'h00E0, 16'h4444, 0);
    chk("R12 nop pc", next_pc, 16'h0700);
    chk("R12 nop sp", next_sp, 16'h00E0);
    chk("R12 nop we", {13'b0, rf_we, mem_we, port_we}, 16'h0);
    issue(4'd0, 0, 0, 16'h0050, 16'h0710, 16'h00E0, 0, 0);
    chk("R12 op0 pc", next_pc, 16'h0710);
    @(negedge clk);
    in_op = 4'd5; in_rs = 8'hEE; in_k = 16'h0011; in_pc = 16'h0999;
    @(negedge clk);
    chk("R13 idle valid", {15'b0, out_valid}, 16'h0);
    chk("R13 idle port we", {15'b0, port_we}, 16'h0);
    chk("R13 idle port data", {8'h0, port_wdata}, 16'h00C3);
    chk("R13 idle pc held", next_pc, 16'h0710);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_branch_taken();
    t_dec_and_branch();
    t_xor();
    t_jump();
    t_call_ret();
    t_ports_store();
    t_undef_idle();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule